// File: doc/BRIEF.md
# DSP Core Power and Reset Sequencer

This block brings a single DSP core up and takes it down again. It drives three controls: a power request, a core reset and a core stall. It gets back the core's power status and readbacks of reset and stall. A one-cycle command strobe with a command kind starts one of two jobs, boot or disable. The sequencer then writes the controls one step at a time. After each write it waits for the matching status before it moves on.

The boot path depends on the state of the core. A core counts as healthy when the power status is high, the power request is high, and the reset and stall readbacks are both low. A healthy core gets a short restart: stall, reset, release of reset, then run. Power stays on throughout. Any other core gets a full disable followed by a full enable. Every wait step has a timeout of `TIMEOUT_CYC` cycles. A wait that runs out ends the job with an error. At the end of every job, `done` pulses for one cycle, and `err` shows the result until the next job is accepted.

Top module: `core_boot_seq`

## Requirements
- R1: After reset, `pwrReq` is 0, `coreRst` is 1, `coreStall` is 1, and `busy`, `done` and `err` are all 0.
- R2: A boot (`cmdKind`=0) on a healthy core asserts stall and reset and waits for the reset readback to go high. It then releases reset and stall and ends without error. `pwrReq` stays high for the whole job.
- R3: A boot on a core that is not healthy first stalls and resets it and drops `pwrReq` until the power status reads low. It then raises `pwrReq` again and runs the enable sequence.
- R4: The enable sequence raises `pwrReq` and releases `coreRst` only after `pwrStat` reads high.
- R5: The start sequence releases reset and clears `coreStall` only after `rstBack` reads low. If the core is then healthy, the job ends with `err`=0 and the core left running (`pwrReq`=1, `coreRst`=0, `coreStall`=0).
- R6: A disable (`cmdKind`=1) stalls and resets the core, waits for `rstBack` high, then drops `pwrReq` and waits for `pwrStat` low. It ends with `err`=0, `pwrReq`=0, `coreRst`=1 and `coreStall`=1.
- R7: A wait (for power up, power down, reset high or reset low) that sees no matching status for `TIMEOUT_CYC` cycles ends the job with `done` and `err` high. A cold boot whose power never comes up keeps `busy` high for exactly `TIMEOUT_CYC`+2 cycles.
- R8: If the core is not healthy in the cycle after stall is cleared, the sequencer sets stall and reset again and ends the job with `err`=1.
- R9: A command that arrives while `busy` is high has no effect. The running job finishes as if the command had not come, and no second `done` pulse follows.
- R10: `busy` rises in the cycle after a command is accepted. `done` is a single-cycle pulse, and `busy` is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | One-cycle command strobe, taken only when idle |
| cmdKind | input | 1 | 0 = boot, 1 = disable |
| pwrStat | input | 1 | Current power status of the core |
| rstBack | input | 1 | Readback of core reset |
| stallBack | input | 1 | Readback of core stall |
| pwrReq | output | 1 | Power request to the core |
| coreRst | output | 1 | Core reset, active high |
| coreStall | output | 1 | Core stall, active high |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse at the end of a job |
| err | output | 1 | Result of the last job, 1 = failed |

## Verification
On every cycle, the assertions check the ordering of the handshake. Reset is released only while the power status is high. Stall is cleared only after the reset readback has gone low. Power is dropped only while the core is held in stall and reset. They also check the shape of the `done`/`busy`/`err` hand-off. Only the bench scenarios can show which path a boot takes for a healthy or an unhealthy core, the exact timeout length, the fallback into stall and reset after a failed start, and that a command sent while busy has no effect.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;

  typedef enum logic {
    CMD_BOOT = 1'b0,
    CMD_OFF  = 1'b1
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,    // stall+reset written, wait reset readback high
    ST_PDN,    // power request dropped, wait status low
    ST_PUP,    // power request raised, wait status high
    ST_UNRST,  // reset released, wait readback low
    ST_RUN     // stall cleared, check health
  } state_e;

  typedef enum logic [1:0] {
    MODE_OFF,
    MODE_RESTART,
    MODE_FULL
  } mode_e;

  typedef struct packed {
    logic setPwr;
    logic clrPwr;
    logic setRst;
    logic clrRst;
    logic setStall;
    logic clrStall;
    logic tmrClr;
    logic clrErr;
    logic finishOk;
    logic finishErr;
  } strobe_t;

endpackage

// File: rtl/core_seq_dp.sv
module core_seq_dp
  import core_seq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 50
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  output logic    pwrReq,
  output logic    coreRst,
  output logic    coreStall,
  output logic    done,
  output logic    err,
  output logic    tmrExpired
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);
  localparam logic [TW-1:0] TOP  = TW'(TIMEOUT_CYC);

  logic [TW-1:0] timer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrReq    <= 1'b0;
      coreRst   <= 1'b1;
      coreStall <= 1'b1;
      done      <= 1'b0;
      err       <= 1'b0;
      timer     <= '0;
    end else begin
      if (stb.setPwr)        pwrReq <= 1'b1;
      else if (stb.clrPwr)   pwrReq <= 1'b0;
      if (stb.setRst)        coreRst <= 1'b1;
      else if (stb.clrRst)   coreRst <= 1'b0;
      if (stb.setStall)      coreStall <= 1'b1;
      else if (stb.clrStall) coreStall <= 1'b0;
      done <= stb.finishOk | stb.finishErr;
      if (stb.clrErr)         err <= 1'b0;
      else if (stb.finishErr) err <= 1'b1;
      if (stb.tmrClr)        timer <= '0;
      else if (timer != TOP) timer <= timer + 1'b1;
    end
  end

  assign tmrExpired = (timer == LAST);
endmodule

// File: rtl/core_seq_ctrl.sv
module core_seq_ctrl
  import core_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic    cmdKind,
  input  logic    pwrStat,
  input  logic    rstBack,
  input  logic    stallBack,
  input  logic    pwrReq,
  input  logic    tmrExpired,
  output strobe_t stb,
  output logic    busy
);
  state_e state, stateNxt;
  mode_e  mode, modeNxt;
  logic   healthy;

  assign healthy = pwrStat & pwrReq & ~rstBack & ~stallBack;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    stb      = '0;
    stateNxt = state;
    modeNxt  = mode;
    unique case (state)
      ST_IDLE: if (cmdValid) begin
        stb.setStall = 1'b1;
        stb.setRst   = 1'b1;
        stb.tmrClr   = 1'b1;
        stb.clrErr   = 1'b1;
        stateNxt     = ST_RST;
        if (cmdKind == CMD_OFF) modeNxt = MODE_OFF;
        else if (healthy)       modeNxt = MODE_RESTART;
        else                    modeNxt = MODE_FULL;
      end
      ST_RST: if (rstBack) begin
        stb.tmrClr = 1'b1;
        if (mode == MODE_RESTART) begin
          stb.clrRst = 1'b1;
          stateNxt   = ST_UNRST;
        end else begin
          stb.clrPwr = 1'b1;
          stateNxt   = ST_PDN;
        end
      end else if (tmrExpired) begin
        stb.finishErr = 1'b1;
        stateNxt      = ST_IDLE;
      end
      ST_PDN: if (!pwrStat) begin
        if (mode == MODE_OFF) begin
          stb.finishOk = 1'b1;
          stateNxt     = ST_IDLE;
        end else begin
          stb.setPwr = 1'b1;
          stb.tmrClr = 1'b1;
          stateNxt   = ST_PUP;
        end
      end else if (tmrExpired) begin
        stb.finishErr = 1'b1;
        stateNxt      = ST_IDLE;
      end
      ST_PUP: if (pwrStat) begin
        stb.clrRst = 1'b1;
        stb.tmrClr = 1'b1;
        stateNxt   = ST_UNRST;
      end else if (tmrExpired) begin
        stb.finishErr = 1'b1;
        stateNxt      = ST_IDLE;
      end
      ST_UNRST: if (!rstBack) begin
        stb.clrStall = 1'b1;
        stateNxt     = ST_RUN;
      end else if (tmrExpired) begin
        stb.finishErr = 1'b1;
        stateNxt      = ST_IDLE;
      end
      ST_RUN: begin
        stateNxt = ST_IDLE;
        if (healthy) stb.finishOk = 1'b1;
        else begin
          stb.setStall  = 1'b1;
          stb.setRst    = 1'b1;
          stb.finishErr = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      mode  <= MODE_OFF;
    end else begin
      state <= stateNxt;
      mode  <= modeNxt;
    end
  end
endmodule

// File: rtl/core_boot_seq.sv
module core_boot_seq
  import core_seq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdValid,
  input  logic cmdKind,
  input  logic pwrStat,
  input  logic rstBack,
  input  logic stallBack,
  output logic pwrReq,
  output logic coreRst,
  output logic coreStall,
  output logic busy,
  output logic done,
  output logic err
);
  strobe_t stb;
  logic    tmrExpired;

  core_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .pwrStat(pwrStat), .rstBack(rstBack), .stallBack(stallBack),
    .pwrReq(pwrReq), .tmrExpired(tmrExpired), .stb(stb), .busy(busy)
  );

  core_seq_dp #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pwrReq(pwrReq), .coreRst(coreRst),
    .coreStall(coreStall), .done(done), .err(err), .tmrExpired(tmrExpired)
  );
endmodule

// File: rtl/core_seq_chk.sv
module core_seq_chk (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic pwrStat,
  input logic rstBack,
  input logic pwrReq,
  input logic coreRst,
  input logic coreStall,
  input logic busy,
  input logic done,
  input logic err
);
  AST_RST_AFTER_PWR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreRst) |-> pwrStat) else $error("reset released without power"); // R4

  AST_RUN_AFTER_UNRST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreStall) |-> (!rstBack && pwrStat)) else $error("stall cleared early"); // R5

  AST_PWR_DROP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrReq) |-> (coreRst && coreStall && rstBack)) else $error("power dropped on live core"); // R6

  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> done) else $error("err rose outside done"); // R7

  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid)) else $error("busy without command"); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy) else $error("busy during done"); // R10
endmodule

bind core_boot_seq core_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .pwrStat(pwrStat),
  .rstBack(rstBack), .pwrReq(pwrReq), .coreRst(coreRst),
  .coreStall(coreStall), .busy(busy), .done(done), .err(err)
);

// File: tb/sim_core_boot_seq.sv
`timescale 1ns/1ps
module sim_core_boot_seq;
  localparam int TO = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdKind = 1'b0;
  logic pwrReq, coreRst, coreStall, busy, done, err;
  logic pwrStat, rstBack, stallBack;

  // core model: readbacks follow controls with a 3-cycle lag
  logic [2:0] pwrPipe, rstPipe;
  logic stuckPwrLo = 1'b0, stuckPwrHi = 1'b0, stuckRst = 1'b0, forceStall = 1'b0;

  int testCnt = 0;
  int failCnt = 0;
  int cycles = 0;
  bit sawPwrFall, sawRstHigh;
  int donePulses;
  logic prevPwr;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrPipe <= 3'b000;
      rstPipe <= 3'b111;
    end else begin
      pwrPipe <= {pwrPipe[1:0], pwrReq};
      rstPipe <= {rstPipe[1:0], coreRst};
    end
  end
  assign pwrStat   = stuckPwrLo ? 1'b0 : (stuckPwrHi ? 1'b1 : pwrPipe[2]);
  assign rstBack   = stuckRst ? 1'b1 : rstPipe[2];
  assign stallBack = forceStall ? 1'b1 : coreStall;

  core_boot_seq #(.TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .pwrStat(pwrStat), .rstBack(rstBack), .stallBack(stallBack),
    .pwrReq(pwrReq), .coreRst(coreRst), .coreStall(coreStall),
    .busy(busy), .done(done), .err(err)
  );

  always @(negedge clk) begin
    cycles++;
    if (prevPwr && !pwrReq) sawPwrFall = 1'b1;
    if (coreRst) sawRstHigh = 1'b1;
    if (done) donePulses++;
    prevPwr = pwrReq;
    if (cycles > 100000) begin
      failCnt++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    sawPwrFall = 1'b0;
    sawRstHigh = 1'b0;
    donePulses = 0;
  endtask

  task automatic sendCmd(input logic kind);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdKind  = kind;
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy == 1'b1, "R10 busy after accept", busy, 1);
  endtask

  // waits for done; returns busy cycles counted before it
  task automatic waitDone(output int busyCycles, output logic errOut);
    int n;
    n = 1;  // the cycle seen in sendCmd
    busyCycles = 0;
    errOut = 1'b0;
    while (!done && n < 2000) begin
      @(negedge clk);
      if (busy) n++;
    end
    busyCycles = n;
    check(done == 1'b1, "R10 done seen", done, 1);
    check(busy == 1'b0, "R10 busy low at done", busy, 0);
    errOut = err;
    @(negedge clk);
    check(done == 1'b0, "R10 done one cycle", done, 0);
  endtask

  task automatic checkRunning(input string tag);
    check(pwrReq == 1'b1, {tag, " pwrReq"}, pwrReq, 1);
    check(coreRst == 1'b0, {tag, " coreRst"}, coreRst, 0);
    check(coreStall == 1'b0, {tag, " coreStall"}, coreStall, 0);
  endtask

  task automatic testReset();
    check(pwrReq == 1'b0, "R1 pwrReq", pwrReq, 0);
    check(coreRst == 1'b1, "R1 coreRst", coreRst, 1);
    check(coreStall == 1'b1, "R1 coreStall", coreStall, 1);
    check({busy, done, err} == 3'b000, "R1 busy/done/err", {busy, done, err}, 0);
  endtask

  task automatic testColdBoot();
    int b; logic e;
    sendCmd(1'b0);
    waitDone(b, e);
    check(e == 1'b0, "R4 R5 cold boot err", e, 0);
    checkRunning("R5 cold boot");
  endtask

  task automatic testRestart();
    int b; logic e;
    clearMon();
    sendCmd(1'b0);
    waitDone(b, e);
    check(e == 1'b0, "R2 restart err", e, 0);
    check(sawPwrFall == 1'b0, "R2 power kept", sawPwrFall, 0);
    check(sawRstHigh == 1'b1, "R2 reset pulsed", sawRstHigh, 1);
    checkRunning("R2 restart");
  endtask

  task automatic testDisable();
    int b; logic e;
    sendCmd(1'b1);
    waitDone(b, e);
    check(e == 1'b0, "R6 disable err", e, 0);
    check({pwrReq, coreRst, coreStall} == 3'b011, "R6 end state",
          {pwrReq, coreRst, coreStall}, 3);
  endtask

  task automatic testIgnoreBusy();
    int b; logic e;
    clearMon();
    sendCmd(1'b0);
    cmdValid = 1'b1;
    cmdKind  = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    waitDone(b, e);
    repeat (12) @(negedge clk);
    check(busy == 1'b0, "R9 no second job", busy, 0);
    check(donePulses == 1, "R9 single done", donePulses, 1);
    checkRunning("R9 boot kept");
  endtask

  task automatic testStartFail();
    int b; logic e;
    forceStall = 1'b1;
    sendCmd(1'b0);
    waitDone(b, e);
    check(e == 1'b1, "R8 err", e, 1);
    check(coreRst == 1'b1, "R8 coreRst", coreRst, 1);
    check(coreStall == 1'b1, "R8 coreStall", coreStall, 1);
    forceStall = 1'b0;
  endtask

  task automatic testFullRecover();
    int b; logic e;
    clearMon();
    sendCmd(1'b0);
    waitDone(b, e);
    check(sawPwrFall == 1'b1, "R3 power cycled", sawPwrFall, 1);
    check(e == 1'b0, "R3 err", e, 0);
    checkRunning("R3 recover");
  endtask

  task automatic testPdnTimeout();
    int b; logic e;
    stuckPwrHi = 1'b1;
    sendCmd(1'b1);
    waitDone(b, e);
    check(e == 1'b1, "R7 power-down timeout err", e, 1);
    stuckPwrHi = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic testPupTimeout();
    int b; logic e;
    stuckPwrLo = 1'b1;
    sendCmd(1'b0);
    waitDone(b, e);
    check(e == 1'b1, "R7 power-up timeout err", e, 1);
    check(b == TO + 2, "R7 timeout length", b, TO + 2);
    stuckPwrLo = 1'b0;
    sendCmd(1'b1);
    waitDone(b, e);
    check(e == 1'b0, "R6 clean disable", e, 0);
  endtask

  task automatic testUnrstTimeout();
    int b; logic e;
    stuckRst = 1'b1;
    sendCmd(1'b0);
    waitDone(b, e);
    check(e == 1'b1, "R7 reset-release timeout err", e, 1);
    stuckRst = 1'b0;
  endtask

  initial begin
    clearMon();
    prevPwr = 1'b0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testColdBoot();
    testRestart();
    testDisable();
    testIgnoreBusy();
    testStartFail();
    testFullRecover();
    testPdnTimeout();
    testPupTimeout();
    testUnrstTimeout();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule